// File: doc/BRIEF.md
# Synchronous serial link port

This block is a full-duplex byte-wide serial port that a CPU reaches through two registers on a simple bus. One register holds the data byte. The other is the control register, which selects the clock source and starts a transfer. A transfer moves eight bits out of the data register and eight bits into it at the same time, most significant bit first. There are no framing bits.

The shift clock has two possible sources. The first is an internal divider of the system clock, in which case the block drives the clock pin. The second is an external pin that a link partner drives. The block changes its serial output on the falling edge of the shift clock and samples its serial input on the rising edge. It detects both edges synchronously in the system clock domain.

When the eighth bit has been sampled, three things happen. The received byte is in the data register. The busy bit in the control register clears itself. The interrupt request goes high for one system clock.

Top module: `serial_link_port`

## Requirements
- R1: After reset, the data register reads 0x00, the control register reads 0x00, `sclk_o` is high, `sclk_oe_o` is low, `sdata_o` is high and `irq_o` is low.
- R2: A transfer sends the byte that was in the data register to the partner. When the transfer completes, the byte received from the partner has replaced the contents of the data register.
- R3: Bits leave and arrive most significant bit first. The first bit sampled lands in bit 7 of the received byte, and the first bit driven is bit 7 of the byte being sent.
- R4: `sclk_oe_o` equals control bit 0. With the internal clock selected, `sclk_o` is high when idle. During a transfer it goes low exactly eight times, and each low phase and each high phase lasts DIV_HALF system clocks.
- R5: `sdata_o` changes only on falling shift-clock edges. After a transfer it holds the last bit sent (bit 0 of the byte sent) until the next transfer drives a new bit.
- R6: The CPU reaches two registers through `addr_i`: address 0 is the data register and address 1 is the control register. A write to the control register with bit 7 set starts a transfer, and bit 0 of the same write selects the internal clock (1) or the external pin (0). Control bit 7 reads 1 while a transfer is in progress. The control register reads as {busy, 6'b0, clock select}.
- R7: With the internal clock, `irq_o` goes high exactly 16*DIV_HALF system clocks after the clock edge that captured the start write. It stays high for one cycle, and busy is low from that cycle on.
- R8: If `sdata_i` is held high because no partner is present, the received byte is 0xFF.
- R9: With the external clock, the transfer completes after eight rising edges on `sclk_i`, and busy stays set until the eighth one. Edges on `sclk_i` while the port is idle change neither the data register nor `sdata_o`, and raise no interrupt.
- R10: A data-register write during a transfer is ignored. A data-register read during a transfer returns the partly shifted value.
- R11: A control-register write during a transfer is ignored: it neither stops the transfer nor changes the clock selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 = data, 1 = control |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the register selected by `addr_i` |
| sclk_i | input | 1 | External shift clock pin |
| sclk_o | output | 1 | Internal shift clock level |
| sclk_oe_o | output | 1 | Clock pin output enable (high when the internal clock is selected) |
| sdata_i | input | 1 | Serial input, pulled high when no partner is present |
| sdata_o | output | 1 | Serial output |
| irq_o | output | 1 | Transfer-complete interrupt request, one cycle wide |

## Verification
Transfers on the internal clock use random pairs of sent and partner bytes, with a directed pair of 0x80 and 0x00 that exposes a reversed bit order or an off-by-one bit count. A share of these transfers run with no partner, and the 0xFF result separates a floating or zero-filled input from the pull-up. The bench, acting as partner, collects the bits the port sends. It counts clock low phases and the cycle on which the interrupt arrives, and reads the data register halfway through a transfer, which shows the shift direction and where the half-shifted bits sit. Externally clocked transfers are preceded by pin toggles while the port is idle, which separates a port that wrongly reacts to those toggles from one that correctly ignores them.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int   CTRL_SEL_BIT = 0;

  typedef enum logic {
    CLK_EXT = 1'b0,
    CLK_INT = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } sedge_t;
endpackage

// File: rtl/slp_int_clk.sv
module slp_int_clk
  import slp_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  output logic   sclk_o,
  output sedge_t edge_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
    end else if (tick) begin
      cnt_q   <= '0;
      level_q <= ~level_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o      = level_q;
  assign edge_o.fall = tick & level_q;
  assign edge_o.rise = tick & ~level_q;
endmodule

// File: rtl/slp_ext_clk.sv
module slp_ext_clk
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sclk_i,
  output sedge_t edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= sclk_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_o.fall = prev_q & ~sync_q[SYNC_STAGES-1];
  assign edge_o.rise = ~prev_q & sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/slp_shifter.sv
module slp_shifter
  import slp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  sedge_t            edge_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] shreg_o,
  output logic              busy_o,
  output logic              sdata_o,
  output logic              done_o
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [BW-1:0]     bits_q;
  logic              busy_q, out_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      bits_q  <= '0;
      busy_q  <= 1'b0;
      out_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          bits_q <= '0;
        end else if (load_i) begin
          shreg_q <= load_data_i;
        end
      end else begin
        if (edge_i.fall) out_q <= shreg_q[DATA_W-1];
        if (edge_i.rise) begin
          shreg_q <= {shreg_q[DATA_W-2:0], sdata_i};
          bits_q  <= bits_q + 1'b1;
          if (bits_q == BIT_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign shreg_o = shreg_q;
  assign busy_o  = busy_q;
  assign sdata_o = out_q;
  assign done_o  = done_q;
endmodule

// File: rtl/serial_link_port.sv
module serial_link_port
  import slp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              irq_o
);
  localparam int START_BIT = DATA_W - 1;

  clk_src_e          clk_sel_q;
  logic              busy, start, load_data, wr_ctrl;
  logic [DATA_W-1:0] shreg;
  sedge_t            int_edge, ext_edge, sel_edge;

  assign wr_ctrl   = wr_i && (addr_i == ADDR_CTRL) && !busy;
  assign start     = wr_ctrl && wdata_i[START_BIT];
  assign load_data = wr_i && (addr_i == ADDR_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      clk_sel_q <= CLK_EXT;
    else if (wr_ctrl) clk_sel_q <= clk_src_e'(wdata_i[CTRL_SEL_BIT]);
  end

  slp_int_clk #(.DIV_HALF(DIV_HALF)) u_int_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && (clk_sel_q == CLK_INT)),
    .sclk_o (sclk_o),
    .edge_o (int_edge)
  );

  slp_ext_clk #(.SYNC_STAGES(SYNC_STAGES)) u_ext_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .edge_o (ext_edge)
  );

  assign sel_edge = (clk_sel_q == CLK_INT) ? int_edge : ext_edge;

  slp_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .load_i      (load_data),
    .load_data_i (wdata_i),
    .edge_i      (sel_edge),
    .sdata_i     (sdata_i),
    .shreg_o     (shreg),
    .busy_o      (busy),
    .sdata_o     (sdata_o),
    .done_o      (irq_o)
  );

  always_comb begin
    if (addr_i == ADDR_CTRL) begin
      rdata_o = '0;
      rdata_o[START_BIT]    = busy;
      rdata_o[CTRL_SEL_BIT] = (clk_sel_q == CLK_INT);
    end else begin
      rdata_o = shreg;
    end
  end

  assign sclk_oe_o = (clk_sel_q == CLK_INT);
endmodule

// File: rtl/slp_checker.sv
module slp_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_i,
  input logic busy_i,
  input logic sclk_i,
  input logic sdata_i,
  input logic oe_i
);
  a_r7_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);
  a_r7_irq_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> irq_i);
  a_r7_irq_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> !busy_i);
  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sclk_i);
  a_r9_ext_int_clk_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> sclk_i);
  a_r5_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i)) |-> $stable(sdata_i));
  a_r11_sel_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(oe_i));
endmodule

bind serial_link_port slp_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_i   (irq_o),
  .busy_i  (busy),
  .sclk_i  (sclk_o),
  .sdata_i (sdata_o),
  .oe_i    (sclk_oe_o)
);

// File: tb/tb_serial_link_port.sv
module tb_serial_link_port;
  localparam int H = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, sclk_in = 1'b1, sdin = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk_out, sclk_oe, sdout, irq;
  int         n_cmp = 0, n_fail = 0, irq_cnt = 0;
  bit         done = 1'b0;

  serial_link_port #(.DATA_W(8), .DIV_HALF(H), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_i(sclk_in), .sclk_o(sclk_out), .sclk_oe_o(sclk_oe),
    .sdata_i(sdin), .sdata_o(sdout), .irq_o(irq));

  always #5 clk = ~clk;
  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [7:0] exp_partial(input logic [7:0] sent, input logic [7:0] got, input int k);
    logic [15:0] cat = {sent, got};
    return 8'((cat << k) >> 8);
  endfunction

  task automatic run_int(input logic [7:0] d, input logic [7:0] p, input bit partner);
    logic [7:0] pe = partner ? p : 8'hFF;
    logic [7:0] rx = '0, rv;
    int pidx = 0, falls = 0, lows = 0, n = 0, irq0;
    logic prev;
    bus_write(1'b0, d);
    sdin = pe[7];
    irq0 = irq_cnt;
    bus_write(1'b1, 8'h81);
    prev = sclk_out;
    while (n < 16*H + 20) begin
      @(negedge clk); n++;
      if (wr) wr = 1'b0;
      if (sclk_out == 1'b0) lows++;
      if (prev && !sclk_out) falls++;
      if (!prev && sclk_out) begin
        rx = {rx[6:0], sdout};
        pidx++;
        if (pidx < 8) begin rv = pe << pidx; sdin = rv[7]; end
      end
      prev = sclk_out;
      if (n == 3*H) begin addr = 1'b1; wr = 1'b1; wdata = 8'h00; end        // R11
      if (n == 5*H) begin addr = 1'b0; wr = 1'b1; wdata = ~d; end           // R10
      if (n == 9*H) begin
        bus_read(1'b0, rv); chk("R10 partial read", rv, exp_partial(d, pe, 4));
      end
      if (n == 11*H) begin bus_read(1'b1, rv); chk("R6 busy reads 1", rv, 8'h81); end
      if (irq) break;
    end
    chk("R7 irq cycle", 8'(n), 8'(16*H));
    chk("R4 eight low pulses", 8'(falls), 8'd8);
    chk("R4 low phase length", 8'(lows), 8'(8*H));
    bus_read(1'b0, rv);
    chk(partner ? "R2 received byte" : "R8 no partner gives FF", rv, pe);
    chk("R3 partner got msb first", rx, d);
    bus_read(1'b1, rv); chk("R6 busy cleared", rv, 8'h01);
    @(negedge clk);
    chk("R7 irq one cycle", {7'd0, irq}, 8'd0);
    chk("R7 one irq", 8'(irq_cnt - irq0), 8'd1);
    repeat (3) @(negedge clk);
    chk("R5 out holds last bit", {7'd0, sdout}, {7'd0, d[0]});
    chk("R4 idle high", {7'd0, sclk_out}, 8'd1);
  endtask

  task automatic run_ext(input logic [7:0] d, input logic [7:0] p);
    logic [7:0] rx = '0, rv;
    int irq0;
    logic out0;
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, d);
    chk("R4 oe low when external", {7'd0, sclk_oe}, 8'd0);
    irq0 = irq_cnt; out0 = sdout;
    for (int t = 0; t < 2; t++) begin
      sclk_in = 1'b0; repeat (6) @(negedge clk);
      sclk_in = 1'b1; repeat (6) @(negedge clk);
    end
    bus_read(1'b0, rv); chk("R9 idle edges keep data", rv, d);
    chk("R9 idle edges keep output", {7'd0, sdout}, {7'd0, out0});
    chk("R9 idle edges no irq", 8'(irq_cnt - irq0), 8'd0);
    sdin = p[7];
    bus_write(1'b1, 8'h80);
    for (int b = 0; b < 8; b++) begin
      sclk_in = 1'b0; rv = p << b; sdin = rv[7];
      repeat (6) @(negedge clk);
      rx = {rx[6:0], sdout};
      if (b == 7) begin bus_read(1'b1, rv); chk("R9 busy before eighth rise", rv, 8'h80); end
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    bus_read(1'b0, rv); chk("R9 external received", rv, p);
    chk("R9 external sent msb first", rx, d);
    bus_read(1'b1, rv); chk("R9 busy cleared", rv, 8'h00);
    chk("R9 one irq", 8'(irq_cnt - irq0), 8'd1);
    chk("R5 out holds last bit ext", {7'd0, sdout}, {7'd0, d[0]});
  endtask

  initial begin
    logic [7:0] rv;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(1'b0, rv); chk("R1 data reset", rv, 8'h00);
    bus_read(1'b1, rv); chk("R1 ctrl reset", rv, 8'h00);
    chk("R1 pins reset", {4'd0, sclk_out, sclk_oe, sdout, irq}, 8'b0000_1010);
    run_int(8'h80, 8'h00, 1'b1);
    run_int(8'h01, 8'hA5, 1'b0);
    bus_read(1'b1, rv); chk("R4 oe high when internal", {7'd0, sclk_oe}, 8'd1);
    for (int i = 0; i < 24; i++)
      run_int(8'($urandom), 8'($urandom), ($urandom % 4) != 0);
    run_ext(8'hC3, 8'h5A);
    for (int i = 0; i < 4; i++) run_ext(8'($urandom), 8'($urandom));
    run_int(8'h3C, 8'h96, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end
endmodule